// File: doc/BRIEF.md
# Operand Specifier Address Sequencer

This block resolves a single operand specifier for a two-address machine with 16-bit words and eight general registers. Register 6 serves as the stack pointer and register 7 as the program counter. A request carries a 3-bit mode, a 3-bit register number and a byte/word flag. The sequencer reads and rewrites the register file through a one-read, one-write port. In the indexed modes it pulls one word from the instruction stream. In the deferred modes it reads one pointer word from memory. It then reports either that the operand is the register itself or the final memory address of the operand. The operand data itself is fetched elsewhere.

Requests enter on a valid/ready pair. `in_ready` is high only when the sequencer is idle, and a request is taken on a clock edge where both `in_valid` and `in_ready` are high. The result leaves as a one-cycle `out_valid` pulse with no back-pressure, so the consumer must capture it in that cycle. The instruction-stream port and the memory port are req/ack reads. Each request stays asserted with a stable address until the clock edge on which ack is high, and the data is taken on that edge. The sequencer waits for as many cycles as ack is withheld.

The register file read is combinational: `rf_rd_data` must reflect `rf_rd_idx` in the same cycle. A write pulse on `rf_we` takes effect at the following clock edge.

Top module: `opspec_seq`

## Requirements
- R1: Mode 0 reports `out_is_reg`=1, `out_reg` = the register number and `out_addr`=0. It performs no register write and no memory or instruction-stream read.
- R2: Mode 1 reports the register's value as the address and leaves the register unchanged.
- R3: Mode 2 reports the register's old value as the address and writes old value + step back to the register. With register 7 this addresses an immediate word and moves the PC past it. With register 6 it acts as a pop.
- R4: Mode 3 reads memory at the register's old value, reports the word read as the address, and writes old value + step back to the register. With register 7 this is absolute addressing.
- R5: Mode 4 writes old value − step to the register and reports that new value as the address. With register 6 it acts as a push. Arithmetic wraps modulo 2^16.
- R6: Mode 5 writes old value − step to the register, reads memory at that new value, and reports the word read as the address.
- R7: Mode 6 takes one instruction-stream word X and advances register 7 by 2. It reports register + X as the address. When the register is 7, the already-advanced PC is used, which gives PC-relative addressing.
- R8: Mode 7 forms the same sum as mode 6, reads memory at that sum, and reports the word read as the address.
- R9: The step is 2 for word requests. For byte requests (`in_byte`=1) the step is 1 for registers 0 to 5 and 2 for registers 6 and 7.
- R10: `mem_req` and `istr_req` stay high until acknowledged, and `mem_addr` holds steady meanwhile. The sequencer stalls for any number of cycles without ack.
- R11: `in_ready` is high only when idle, with no read outstanding and no result being presented. It drops in the cycle after a request is accepted.
- R12: Each operand produces exactly one `out_valid` pulse of one cycle. Modes 2 to 7 produce exactly one register write each, and modes 0 and 1 produce none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Specifier request valid |
| in_ready | output | 1 | Sequencer idle, request can be taken |
| in_mode | input | 3 | Addressing mode 0..7 |
| in_reg | input | 3 | Register number 0..7 |
| in_byte | input | 1 | 1 = byte access, 0 = word access |
| out_valid | output | 1 | One-cycle result pulse |
| out_is_reg | output | 1 | Operand is the register itself |
| out_reg | output | 3 | Register number of the specifier |
| out_addr | output | 16 | Final operand address (0 when out_is_reg) |
| rf_rd_idx | output | 3 | Register file read index |
| rf_rd_data | input | 16 | Register file read data, combinational |
| rf_we | output | 1 | Register file write pulse |
| rf_wr_idx | output | 3 | Register file write index |
| rf_wr_data | output | 16 | Register file write data |
| istr_req | output | 1 | Instruction-stream word request |
| istr_ack | input | 1 | Instruction-stream word present |
| istr_data | input | 16 | Instruction-stream word |
| mem_req | output | 1 | Pointer read request |
| mem_addr | output | 16 | Pointer read address |
| mem_ack | input | 1 | Pointer read data present |
| mem_rdata | input | 16 | Pointer read data |

## Verification
The assertions assume three things about the environment. Ack on either read port arrives only while the matching request is high. The register file returns the selected register in the same cycle. A new request is presented only while the sequencer is idle. The stimulus meets all three. Its responders raise ack only against a pending request, after a delay of zero to two cycles that changes from operation to operation. Its register file model is an array read combinationally and written on the clock edge. It offers each specifier only after the previous result pulse and its write-back have completed. Every mode, register and width combination is swept with varying register contents, and a few wrap-around values are added on top of the sweep.

// File: rtl/opspec_pkg.sv
package opspec_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_IDX  = 2'd1,
    S_PTR  = 2'd2,
    S_DONE = 2'd3
  } seq_state_t;
endpackage

// File: rtl/opspec_step.sv
module opspec_step #(
  parameter int DW   = 16,
  parameter int NREG = 8,
  localparam int RW = $clog2(NREG)
) (
  input  logic          byte_op,
  input  logic [RW-1:0] ridx,
  output logic [DW-1:0] step
);
  // the two top registers (stack pointer, program counter) stay word aligned
  localparam int SP_IDX = NREG - 2;
  always_comb begin
    if (byte_op && (ridx < RW'(SP_IDX))) step = DW'(1);
    else                                 step = DW'(2);
  end
endmodule

// File: rtl/opspec_calc.sv
module opspec_calc #(
  parameter int DW = 16
) (
  input  logic [2:0]    mode,
  input  logic [DW-1:0] val,
  input  logic [DW-1:0] step,
  output logic [DW-1:0] ea,
  output logic [DW-1:0] new_val,
  output logic          wr,
  output logic          need_ptr
);
  logic pre_dec, post_inc;
  logic [DW-1:0] dec_val;
  always_comb begin
    post_inc = (mode[2:1] == 2'b01);
    pre_dec  = (mode[2:1] == 2'b10);
    dec_val  = val - step;
    wr       = post_inc || pre_dec;
    need_ptr = wr && mode[0];
    ea       = pre_dec ? dec_val : val;
    new_val  = pre_dec ? dec_val : (val + step);
  end
endmodule

// File: rtl/opspec_seq.sv
module opspec_seq
  import opspec_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NREG = 8,
  localparam int RW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [2:0]    in_mode,
  input  logic [RW-1:0] in_reg,
  input  logic          in_byte,
  output logic          out_valid,
  output logic          out_is_reg,
  output logic [RW-1:0] out_reg,
  output logic [DW-1:0] out_addr,
  output logic [RW-1:0] rf_rd_idx,
  input  logic [DW-1:0] rf_rd_data,
  output logic          rf_we,
  output logic [RW-1:0] rf_wr_idx,
  output logic [DW-1:0] rf_wr_data,
  output logic          istr_req,
  input  logic          istr_ack,
  input  logic [DW-1:0] istr_data,
  output logic          mem_req,
  output logic [DW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata
);
  localparam logic [RW-1:0] PC_IDX = RW'(NREG - 1);

  seq_state_t    st;
  logic [2:0]    m_q;
  logic [RW-1:0] r_q;
  logic [DW-1:0] v_q, ptr_q, addr_q, wd_q;
  logic          isreg_q, we_q;
  logic [RW-1:0] wi_q;

  logic [DW-1:0] step, ea, new_val, pc_next, idx_sum;
  logic          calc_wr, calc_ptr, accept;

  opspec_step #(.DW(DW), .NREG(NREG)) u_step (
    .byte_op (in_byte),
    .ridx    (in_reg),
    .step    (step)
  );

  opspec_calc #(.DW(DW)) u_calc (
    .mode     (in_mode),
    .val      (rf_rd_data),
    .step     (step),
    .ea       (ea),
    .new_val  (new_val),
    .wr       (calc_wr),
    .need_ptr (calc_ptr)
  );

  always_comb begin
    in_ready  = (st == S_IDLE);
    accept    = in_valid && in_ready;
    rf_rd_idx = (st == S_IDX) ? PC_IDX : in_reg;
    pc_next   = rf_rd_data + DW'(2);
    idx_sum   = ((r_q == PC_IDX) ? pc_next : v_q) + istr_data;
    istr_req  = (st == S_IDX);
    mem_req   = (st == S_PTR);
    mem_addr  = ptr_q;
    out_valid = (st == S_DONE);
    out_is_reg = isreg_q;
    out_reg   = r_q;
    out_addr  = addr_q;
    rf_we     = we_q;
    rf_wr_idx = wi_q;
    rf_wr_data = wd_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      m_q     <= '0;
      r_q     <= '0;
      v_q     <= '0;
      ptr_q   <= '0;
      addr_q  <= '0;
      isreg_q <= 1'b0;
      we_q    <= 1'b0;
      wi_q    <= '0;
      wd_q    <= '0;
    end else begin
      we_q <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          m_q     <= in_mode;
          r_q     <= in_reg;
          v_q     <= rf_rd_data;
          isreg_q <= (in_mode == 3'd0);
          we_q    <= calc_wr;
          wi_q    <= in_reg;
          wd_q    <= new_val;
          if (in_mode == 3'd0) begin
            addr_q <= '0;
            st     <= S_DONE;
          end else if (in_mode[2:1] == 2'b11) begin
            st <= S_IDX;
          end else if (calc_ptr) begin
            ptr_q <= ea;
            st    <= S_PTR;
          end else begin
            addr_q <= ea;
            st     <= S_DONE;
          end
        end
        S_IDX: if (istr_ack) begin
          we_q <= 1'b1;
          wi_q <= PC_IDX;
          wd_q <= pc_next;
          if (m_q[0]) begin
            ptr_q <= idx_sum;
            st    <= S_PTR;
          end else begin
            addr_q <= idx_sum;
            st     <= S_DONE;
          end
        end
        S_PTR: if (mem_ack) begin
          addr_q <= mem_rdata;
          st     <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  logic wb_seen;
  always_ff @(posedge clk) begin
    if (!rst_n)      wb_seen <= 1'b0;
    else if (accept) wb_seen <= 1'b0;
    else if (rf_we)  wb_seen <= 1'b1;
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R12
  AST_WB_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> !wb_seen); // R12
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R10
  AST_ISTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (istr_req && !istr_ack) |=> istr_req); // R10
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!mem_req && !istr_req && !out_valid)); // R11
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready); // R11
  AST_REG_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_is_reg) |-> (out_addr == '0)); // R1
endmodule

// File: tb/test_opspec_seq.sv
module test_opspec_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        in_valid = 1'b0, in_ready, in_byte = 1'b0;
  logic [2:0]  in_mode = '0, in_reg = '0;
  logic        out_valid, out_is_reg;
  logic [2:0]  out_reg, rf_rd_idx, rf_wr_idx;
  logic [15:0] out_addr, rf_rd_data, rf_wr_data, istr_data, mem_addr, mem_rdata;
  logic        rf_we, istr_req, istr_ack, mem_req, mem_ack;

  logic [15:0] regs [8];
  logic [15:0] idx_word = '0;
  int mlat = 0, ilat = 0, mcnt = 0, icnt = 0;
  int we_cnt = 0, ptr_cnt = 0, istr_cnt = 0, hold_err = 0;
  logic [15:0] last_ptr = '0, prev_maddr = '0;
  logic        prev_pend = 1'b0;
  int tests = 0, fails = 0;
  bit finished = 0;

  opspec_seq i_opspec_seq (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_mode(in_mode), .in_reg(in_reg), .in_byte(in_byte),
    .out_valid(out_valid), .out_is_reg(out_is_reg), .out_reg(out_reg), .out_addr(out_addr),
    .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
    .rf_we(rf_we), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
    .istr_req(istr_req), .istr_ack(istr_ack), .istr_data(istr_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  function automatic logic [15:0] memf(logic [15:0] a);
    logic [15:0] r;
    r = a * 16'd3 + 16'h1234;
    return r;
  endfunction

  assign rf_rd_data = regs[rf_rd_idx];
  assign mem_ack    = mem_req && (mcnt >= mlat);
  assign mem_rdata  = memf(mem_addr);
  assign istr_ack   = istr_req && (icnt >= ilat);
  assign istr_data  = idx_word;

  always @(posedge clk) begin
    if (rf_we) begin
      regs[rf_wr_idx] <= rf_wr_data;
      we_cnt <= we_cnt + 1;
    end
    if (mem_req && !mem_ack) mcnt <= mcnt + 1; else mcnt <= 0;
    if (istr_req && !istr_ack) icnt <= icnt + 1; else icnt <= 0;
    if (mem_req && mem_ack) begin
      last_ptr <= mem_addr;
      ptr_cnt  <= ptr_cnt + 1;
    end
    if (istr_req && istr_ack) istr_cnt <= istr_cnt + 1;
    if (prev_pend && (!mem_req || mem_addr != prev_maddr)) hold_err <= hold_err + 1;
    prev_pend  <= mem_req && !mem_ack;
    prev_maddr <= mem_addr;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_op(logic [2:0] m, logic [2:0] r, logic b, logic [15:0] idx, int lat);
    logic [15:0] exp_regs [8];
    logic [15:0] v, stp, e_addr, e_ptr, pcn, sum;
    logic        e_isreg, e_defer;
    int          e_we, base_we, base_ptr, base_istr, e_istr, t;
    string       tag;
    for (int i = 0; i < 8; i++) exp_regs[i] = regs[i];
    v = regs[r];
    stp = (b && r < 3'd6) ? 16'd1 : 16'd2;   // R9
    e_isreg = 1'b0; e_defer = 1'b0; e_ptr = '0; e_addr = '0; e_we = 1; e_istr = 0;
    case (m)
      3'd0: begin tag = "R1"; e_isreg = 1'b1; e_we = 0; end
      3'd1: begin tag = "R2"; e_addr = v; e_we = 0; end
      3'd2: begin tag = "R3"; e_addr = v; exp_regs[r] = v + stp; end
      3'd3: begin tag = "R4"; e_defer = 1'b1; e_ptr = v; e_addr = memf(v); exp_regs[r] = v + stp; end
      3'd4: begin tag = "R5"; exp_regs[r] = v - stp; e_addr = v - stp; end
      3'd5: begin tag = "R6"; exp_regs[r] = v - stp; e_defer = 1'b1; e_ptr = v - stp; e_addr = memf(v - stp); end
      default: begin
        pcn = regs[7] + 16'd2;
        sum = ((r == 3'd7) ? pcn : v) + idx;
        exp_regs[7] = pcn; e_istr = 1;
        if (m == 3'd6) begin tag = "R7"; e_addr = sum; end
        else begin tag = "R8"; e_defer = 1'b1; e_ptr = sum; e_addr = memf(sum); end
      end
    endcase
    base_we = we_cnt; base_ptr = ptr_cnt; base_istr = istr_cnt;
    idx_word = idx; mlat = lat; ilat = 2 - lat;
    in_mode = m; in_reg = r; in_byte = b; in_valid = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0;
    @(negedge clk);
    check("R11", {31'b0, in_ready}, 32'd0, "in_ready after accept");
    t = 0;
    while (!out_valid && t < 50) begin @(negedge clk); t++; end
    check(tag, {31'b0, out_valid}, 32'd1, "result pulse");
    check(tag, {31'b0, out_is_reg}, {31'b0, e_isreg}, "is_reg");
    check(tag, {29'b0, out_reg}, {29'b0, r}, "reg number");
    check(tag, {16'b0, out_addr}, {16'b0, e_addr}, "address");
    @(negedge clk);
    check("R12", {31'b0, out_valid}, 32'd0, "pulse one cycle");
    check("R12", we_cnt - base_we, e_we, "write count");
    for (int i = 0; i < 8; i++)
      check((b && m >= 3'd2 && m <= 3'd5) ? "R9" : tag, {16'b0, regs[i]}, {16'b0, exp_regs[i]}, "register file");
    check(tag, istr_cnt - base_istr, e_istr, "istream reads");
    check(tag, ptr_cnt - base_ptr, e_defer ? 1 : 0, "pointer reads");
    if (e_defer) check(tag, {16'b0, last_ptr}, {16'b0, e_ptr}, "pointer address");
    check("R10", hold_err, 0, "request hold");
  endtask

  task automatic load_regs(int k);
    for (int i = 0; i < 8; i++) regs[i] = 16'h1000 + 16'(i * 16'h0123) + 16'(k * 16'h0047);
  endtask

  initial begin
    load_regs(0);
    repeat (3) @(negedge clk);
    check("R11", {31'b0, in_ready}, 32'd1, "ready after reset");
    check("R12", {31'b0, out_valid}, 32'd0, "no pulse in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", {31'b0, in_ready}, 32'd1, "ready idle");
    for (int m = 0; m < 8; m++)
      for (int r = 0; r < 8; r++)
        for (int b = 0; b < 2; b++) begin
          load_regs(m * 16 + r * 2 + b);
          do_op(3'(m), 3'(r), b[0], 16'(16'h0200 + m * 16'h31 + r * 16'h9), (m + r + b) % 3);
        end
    // wrap-around corners, R5 and R3
    regs[0] = 16'h0000; do_op(3'd4, 3'd0, 1'b0, 16'h0, 1);
    regs[7] = 16'hFFFE; do_op(3'd2, 3'd7, 1'b1, 16'h0, 0);
    regs[6] = 16'h0001; do_op(3'd4, 3'd6, 1'b1, 16'h0, 2);
    regs[7] = 16'hFFFE; do_op(3'd6, 3'd7, 1'b0, 16'hFFF0, 2);
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule